// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This block sits in the execute stage of a small 8-bit processor and settles every change of control flow that does not touch the stack. For each request it gets the address of the current instruction, an operation code, a signed displacement, the status byte and the operands that the condition tests. It returns the address of the next instruction, whether control flow left the sequential path, and how many clock cycles the instruction occupies.

The unit covers unconditional relative jumps, indirect jumps through a 16-bit pointer register, branches on any single status bit chosen by a 3-bit index, signed and unsigned comparison branches, and skips. A skip steps over the following instruction, so the distance depends on whether that instruction is one or two words long; the fetch logic supplies this as `next_long`. Each request is answered on the following clock edge. Instruction fetch, the stack and the flag update are outside this block.

Top module: `bsu_top`

## Requirements
- R1: A request presented with `req_valid` high is answered one clock later with `rsp_valid` high. A cycle without a request gives `rsp_valid` low on the next cycle. Synchronous reset clears `rsp_valid`, `next_pc`, `taken` and `cycles` to zero.
- R2: Operation code 0 (relative jump) gives `next_pc = cur_pc + sext(offset) + 1`, wrapping modulo 2^16, with `taken` = 1 and `cycles` = 2.
- R3: Operation code 1 (indirect jump) gives `next_pc = zptr`, `taken` = 1 and `cycles` = 2. The offset has no effect.
- R4: Code 2 branches when `status[flag_sel]` is 1 and code 3 branches when it is 0. The status bits are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R5: Code 4 (signed greater-or-equal) branches when N XOR V is 0. Code 5 (signed less-than) branches when N XOR V is 1.
- R6: Code 6 (unsigned same-or-higher) branches when C is 0. Code 7 (unsigned lower) branches when C is 1.
- R7: A branch that is taken (codes 2 to 7) loads the same target as R2 and reports 2 cycles. One that is not taken gives `cur_pc + 1` and 1 cycle.
- R8: Code 8 skips when `opnd_a` equals `opnd_b`.
- R9: Code 9 skips when `opnd_a[bit_sel]` is 0 and code 10 when it is 1. Code 11 skips when `io_byte[bit_sel]` is 0 and code 12 when it is 1.
- R10: A skip that is taken gives `cur_pc + 2` and 2 cycles when `next_long` is 0, and `cur_pc + 3` and 3 cycles when `next_long` is 1. A skip that is not taken gives `cur_pc + 1` and 1 cycle whatever `next_long` is. All of these wrap modulo 2^16.
- R11: Codes 13 to 15 are treated as no operation: `next_pc = cur_pc + 1`, `taken` = 0, `cycles` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A decision is requested this cycle |
| op | input | 4 | Operation code (0 to 12, see requirements) |
| cur_pc | input | 16 | Word address of the current instruction |
| offset | input | 12 | Signed relative displacement in words |
| status | input | 8 | Status flags |
| flag_sel | input | 3 | Index of the status bit tested by codes 2 and 3 |
| opnd_a | input | 8 | First register operand |
| opnd_b | input | 8 | Second register operand (equality skip) |
| bit_sel | input | 3 | Bit index for the bit-test skips |
| io_byte | input | 8 | I/O register value for the I/O bit skips |
| next_long | input | 1 | The following instruction is two words long |
| zptr | input | 16 | Pointer register used by the indirect jump |
| rsp_valid | output | 1 | Response valid |
| next_pc | output | 16 | Address of the next instruction |
| taken | output | 1 | Control flow left the sequential path |
| cycles | output | 2 | Cycles used by the instruction (1 to 3) |

## Verification
The bench targets address wraparound. It jumps forward from 0xFFFF, steps backward past zero, and skips a long instruction from 0xFFFE. A design that truncates the sum or forgets the sign extension lands on a wrong page. It walks a single set bit through every `flag_sel` value, which catches a flag index decoded in the wrong bit order, and it runs the signed branches with N and V in all four combinations, so using N or V alone does not get through. Skips are tried with `next_long` both high and low, taken and not taken. A unit that lets the length of the next instruction change a skip that is not taken, or that charges 2 cycles for a long skip, shows up as a wrong address or cycle count.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int PC_W   = 16;
    localparam int OFS_W  = 12;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 8;

    // status bit positions; the flag index decodes against these
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    typedef enum logic [3:0] {
        OP_JREL  = 4'd0,
        OP_JIND  = 4'd1,
        OP_BFSET = 4'd2,
        OP_BFCLR = 4'd3,
        OP_BSGE  = 4'd4,
        OP_BSLT  = 4'd5,
        OP_BUHS  = 4'd6,
        OP_BULO  = 4'd7,
        OP_SKEQ  = 4'd8,
        OP_SKRBC = 4'd9,
        OP_SKRBS = 4'd10,
        OP_SKIOC = 4'd11,
        OP_SKIOS = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } op_e;

    // how the next address is formed
    typedef enum logic [2:0] {
        RT_SEQ   = 3'd0,   // pc + 1
        RT_REL   = 3'd1,   // pc + sext(k) + 1
        RT_IND   = 3'd2,   // pointer
        RT_SKIP1 = 3'd3,   // pc + 2
        RT_SKIP2 = 3'd4    // pc + 3
    } route_e;

    typedef struct packed {
        route_e     route;
        logic       taken;
        logic [1:0] cycles;
    } verdict_t;

    function automatic logic [1:0] route_cost(input route_e r);
        case (r)
            RT_SEQ:   route_cost = 2'd1;
            RT_SKIP2: route_cost = 2'd3;
            default:  route_cost = 2'd2;
        endcase
    endfunction

    function automatic logic is_cond_branch(input op_e o);
        is_cond_branch = (o >= OP_BFSET) && (o <= OP_BULO);
    endfunction

    function automatic logic is_skip(input op_e o);
        is_skip = (o >= OP_SKEQ) && (o <= OP_SKIOS);
    endfunction

endpackage

// File: rtl/bsu_cond.sv
module bsu_cond
    import bsu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FLAG_W,
    localparam int BSEL_W = $clog2(DW),
    localparam int FSEL_W = $clog2(FW)
) (
    input  op_e               op,
    input  logic [FW-1:0]     status,
    input  logic [FSEL_W-1:0] flag_sel,
    input  logic [DW-1:0]     opnd_a,
    input  logic [DW-1:0]     opnd_b,
    input  logic [BSEL_W-1:0] bit_sel,
    input  logic [DW-1:0]     io_byte,
    input  logic              next_long,
    output verdict_t          verdict
);

    logic sel_flag;
    logic signed_lt;
    logic carry;
    logic reg_bit;
    logic io_bit;
    logic cond_hit;
    route_e route;

    always_comb begin
        sel_flag  = status[flag_sel];
        signed_lt = status[FL_N] ^ status[FL_V];
        carry     = status[FL_C];
        reg_bit   = opnd_a[bit_sel];
        io_bit    = io_byte[bit_sel];
    end

    always_comb begin
        case (op)
            OP_BFSET: cond_hit = sel_flag;
            OP_BFCLR: cond_hit = ~sel_flag;
            OP_BSGE:  cond_hit = ~signed_lt;
            OP_BSLT:  cond_hit = signed_lt;
            OP_BUHS:  cond_hit = ~carry;
            OP_BULO:  cond_hit = carry;
            OP_SKEQ:  cond_hit = (opnd_a == opnd_b);
            OP_SKRBC: cond_hit = ~reg_bit;
            OP_SKRBS: cond_hit = reg_bit;
            OP_SKIOC: cond_hit = ~io_bit;
            OP_SKIOS: cond_hit = io_bit;
            default:  cond_hit = 1'b0;
        endcase
    end

    always_comb begin
        route = RT_SEQ;
        if (op == OP_JREL) begin
            route = RT_REL;
        end else if (op == OP_JIND) begin
            route = RT_IND;
        end else if (is_cond_branch(op) && cond_hit) begin
            route = RT_REL;
        end else if (is_skip(op) && cond_hit) begin
            route = next_long ? RT_SKIP2 : RT_SKIP1;
        end
    end

    always_comb begin
        verdict.route  = route;
        verdict.taken  = (route != RT_SEQ);
        verdict.cycles = route_cost(route);
    end

endmodule

// File: rtl/bsu_target.sv
module bsu_target
    import bsu_pkg::*;
#(
    parameter int PW = PC_W,
    parameter int OW = OFS_W
) (
    input  route_e        route,
    input  logic [PW-1:0] cur_pc,
    input  logic [OW-1:0] offset,
    input  logic [PW-1:0] zptr,
    output logic [PW-1:0] next_pc
);

    localparam int EXT_W = PW - OW;

    logic [PW-1:0] ofs_ext;
    logic [PW-1:0] step;

    generate
        if (EXT_W > 0) begin : g_extend
            assign ofs_ext = {{EXT_W{offset[OW-1]}}, offset};
        end else begin : g_trim
            assign ofs_ext = offset[PW-1:0];
        end
    endgenerate

    always_comb begin
        case (route)
            RT_REL:   step = ofs_ext + PW'(1);
            RT_SKIP1: step = PW'(2);
            RT_SKIP2: step = PW'(3);
            default:  step = PW'(1);
        endcase
    end

    always_comb begin
        if (route == RT_IND) next_pc = zptr;
        else                 next_pc = cur_pc + step;
    end

endmodule

// File: rtl/bsu_top.sv
module bsu_top
    import bsu_pkg::*;
#(
    parameter int PW = PC_W,
    parameter int OW = OFS_W,
    parameter int DW = DATA_W,
    parameter int FW = FLAG_W,
    localparam int BSEL_W = $clog2(DW),
    localparam int FSEL_W = $clog2(FW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        op,
    input  logic [PW-1:0]     cur_pc,
    input  logic [OW-1:0]     offset,
    input  logic [FW-1:0]     status,
    input  logic [FSEL_W-1:0] flag_sel,
    input  logic [DW-1:0]     opnd_a,
    input  logic [DW-1:0]     opnd_b,
    input  logic [BSEL_W-1:0] bit_sel,
    input  logic [DW-1:0]     io_byte,
    input  logic              next_long,
    input  logic [PW-1:0]     zptr,
    output logic              rsp_valid,
    output logic [PW-1:0]     next_pc,
    output logic              taken,
    output logic [1:0]        cycles
);

    op_e           op_in;
    verdict_t      verdict;
    logic [PW-1:0] target;

    assign op_in = op_e'(op);

    bsu_cond #(.DW(DW), .FW(FW)) u_cond (
        .op        (op_in),
        .status    (status),
        .flag_sel  (flag_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .bit_sel   (bit_sel),
        .io_byte   (io_byte),
        .next_long (next_long),
        .verdict   (verdict)
    );

    bsu_target #(.PW(PW), .OW(OW)) u_target (
        .route   (verdict.route),
        .cur_pc  (cur_pc),
        .offset  (offset),
        .zptr    (zptr),
        .next_pc (target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            cycles    <= 2'd0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                next_pc <= target;
                taken   <= verdict.taken;
                cycles  <= verdict.cycles;
            end
        end
    end

    a_r1_answer_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r2_jump_always: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op == OP_JREL) |=> (taken && cycles == 2'd2));

    a_r3_pointer_load: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op == OP_JIND) |=> (taken && next_pc == $past(zptr) && cycles == 2'd2));

    a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op != OP_JIND) |=> (taken || next_pc == $past(cur_pc) + PW'(1)));

    a_r10_cost_matches: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (taken ? (cycles == 2'd2 || cycles == 2'd3) : (cycles == 2'd1)));

    a_r10_long_skip: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && cycles == 2'd3) |-> (next_pc == $past(cur_pc) + PW'(3)));

    a_r11_reserved_idle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op >= OP_RSV13) |=> (!taken && cycles == 2'd1));

endmodule

// File: tb/test_bsu_top.sv
module test_bsu_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] cur_pc = '0;
    logic [11:0] offset = '0;
    logic [7:0]  status = '0;
    logic [2:0]  flag_sel = '0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic [2:0]  bit_sel = '0;
    logic [7:0]  io_byte = '0;
    logic        next_long = 1'b0;
    logic [15:0] zptr = '0;
    logic        rsp_valid;
    logic [15:0] next_pc;
    logic        taken;
    logic [1:0]  cycles;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bsu_top i_bsu_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .op(op), .cur_pc(cur_pc),
        .offset(offset), .status(status), .flag_sel(flag_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .bit_sel(bit_sel), .io_byte(io_byte), .next_long(next_long),
        .zptr(zptr), .rsp_valid(rsp_valid), .next_pc(next_pc), .taken(taken),
        .cycles(cycles)
    );

    // expected outcome from the requirements
    function automatic void model(output logic [15:0] epc, output logic et,
                                  output logic [1:0] ec);
        logic hit;
        logic [15:0] rel;
        rel = cur_pc + {{4{offset[11]}}, offset} + 16'd1;
        hit = 1'b0;
        case (op)
            4'd2:  hit = status[flag_sel];
            4'd3:  hit = !status[flag_sel];
            4'd4:  hit = (status[2] == status[3]);
            4'd5:  hit = (status[2] != status[3]);
            4'd6:  hit = !status[0];
            4'd7:  hit = status[0];
            4'd8:  hit = (opnd_a == opnd_b);
            4'd9:  hit = !opnd_a[bit_sel];
            4'd10: hit = opnd_a[bit_sel];
            4'd11: hit = !io_byte[bit_sel];
            4'd12: hit = io_byte[bit_sel];
            default: hit = 1'b0;
        endcase
        epc = cur_pc + 16'd1; et = 1'b0; ec = 2'd1;
        if (op == 4'd0) begin
            epc = rel; et = 1'b1; ec = 2'd2;
        end else if (op == 4'd1) begin
            epc = zptr; et = 1'b1; ec = 2'd2;
        end else if (op >= 4'd2 && op <= 4'd7 && hit) begin
            epc = rel; et = 1'b1; ec = 2'd2;
        end else if (op >= 4'd8 && op <= 4'd12 && hit) begin
            et = 1'b1;
            epc = cur_pc + (next_long ? 16'd3 : 16'd2);
            ec = next_long ? 2'd3 : 2'd2;
        end
    endfunction

    function automatic string op_tag(input logic [3:0] o);
        case (o)
            4'd0: op_tag = "R2";
            4'd1: op_tag = "R3";
            4'd2, 4'd3: op_tag = "R4";
            4'd4, 4'd5: op_tag = "R5";
            4'd6, 4'd7: op_tag = "R6";
            4'd8: op_tag = "R8";
            4'd9, 4'd10, 4'd11, 4'd12: op_tag = "R9";
            default: op_tag = "R11";
        endcase
    endfunction

    function automatic string cost_tag(input logic [3:0] o);
        if (o >= 4'd2 && o <= 4'd7)       cost_tag = "R7";
        else if (o >= 4'd8 && o <= 4'd12) cost_tag = "R10";
        else                              cost_tag = op_tag(o);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s op=%0d pc=%h: actual %h expected %h",
                     tag, what, op, cur_pc, act, exp);
        end
    endtask

    // drive on the falling edge, response registered at the next rising edge,
    // sampled on the falling edge after it
    task automatic apply();
        logic [15:0] epc;
        logic et;
        logic [1:0] ec;
        req_valid = 1'b1;
        model(epc, et, ec);
        @(negedge clk);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(op_tag(op), "next_pc", 32'(next_pc), 32'(epc));
        chk(op_tag(op), "taken", 32'(taken), 32'(et));
        chk(cost_tag(op), "cycles", 32'(cycles), 32'(ec));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1b5e_77a3));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "reset next_pc", 32'(next_pc), 32'd0);
        chk("R1", "reset taken", 32'(taken), 32'd0);
        chk("R1", "reset cycles", 32'(cycles), 32'd0);
        rst = 1'b0;

        // R2: wrap forward and backward, self loop
        op = 4'd0; cur_pc = 16'hFFFF; offset = 12'h000; apply();
        cur_pc = 16'h0005; offset = 12'hFFA; apply();
        cur_pc = 16'h1234; offset = 12'hFFF; apply();
        cur_pc = 16'h0100; offset = 12'h7FF; apply();
        cur_pc = 16'h0100; offset = 12'h800; apply();

        // R3: pointer load ignores offset
        op = 4'd1; zptr = 16'hBEEF; offset = 12'h123; apply();

        // R4: walk one set bit through every flag index
        for (int f = 0; f < 8; f++) begin
            for (int s = 0; s < 8; s++) begin
                status = 8'(1 << s); flag_sel = 3'(f); cur_pc = 16'h0400; offset = 12'h010;
                op = 4'd2; apply();
                op = 4'd3; apply();
            end
        end

        // R5 / R6: all N,V,C combinations
        for (int nv = 0; nv < 8; nv++) begin
            status = {4'b0000, nv[1], nv[0], 1'b0, nv[2]};
            for (int o = 4; o <= 7; o++) begin
                op = 4'(o); cur_pc = 16'h0020; offset = 12'hFF0; apply();
            end
        end

        // R10: skip lengths, wrap, not-taken with long next
        op = 4'd8; opnd_a = 8'h5A; opnd_b = 8'h5A;
        cur_pc = 16'hFFFE; next_long = 1'b1; apply();
        next_long = 1'b0; apply();
        opnd_b = 8'h5B; next_long = 1'b1; apply();
        op = 4'd12; io_byte = 8'h80; bit_sel = 3'd7; cur_pc = 16'h0010; next_long = 1'b1; apply();
        op = 4'd11; apply();

        // R11: reserved codes
        for (int o = 13; o <= 15; o++) begin
            op = 4'(o); cur_pc = 16'hFFFF; apply();
        end

        // random vectors
        for (int i = 0; i < 3000; i++) begin
            op = 4'($urandom_range(0, 15));
            cur_pc = 16'($urandom);
            offset = 12'($urandom);
            status = 8'($urandom);
            flag_sel = 3'($urandom);
            opnd_a = 8'($urandom);
            opnd_b = ($urandom_range(0, 1) == 0) ? opnd_a : 8'($urandom);
            bit_sel = 3'($urandom);
            io_byte = 8'($urandom);
            next_long = 1'($urandom);
            zptr = 16'($urandom);
            apply();
        end

        // R1: idle cycle
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1", "idle rsp_valid", 32'(rsp_valid), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule